// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block recovers asynchronous serial frames from a single line that rests high. A falling edge on the synchronized line marks the start of a frame. From that moment the receiver counts clocks and samples each bit at its middle, using a clocks-per-bit value supplied on an input. It builds a data word of 5 to 9 bits, least or most significant bit first. It can check an optional parity bit, and it then samples one stop bit.

Framing problems do not abort the frame. A start bit that reads high, a parity mismatch and a stop bit that reads low each raise their own one-clock flag, and reception carries on. All configuration inputs are static: they may change only while the receiver is idle between frames.

Top module: `uart_frame_rx`

## Requirements
- R1: Synchronous reset clears all output flags and puts the receiver in idle. A line that is held low through reset and after it does not start a frame. A frame starts only after the line has been seen high and then falls.
- R2: The line passes through two synchronizing flops. A frame starts only when the synchronized line goes from 1 to 0 while the receiver is idle. A rising edge has no effect.
- R3: Let H be `clks_per_bit` shifted right by one bit, and let P be `clks_per_bit`, which must be at least 2. Frame bit n is sampled H + n·P clocks after the edge-detect clock. Bit 0 is the start bit, bits 1..N are data, and the optional parity bit and the stop bit follow. Each flag is asserted for exactly one clock, in the clock after its sample.
- R4: If the start bit reads 1 at its sample point, `err_start` pulses. The rest of the frame is still received and reported.
- R5: `data_len` selects N. Values 5 to 9 are used as given, values below 5 act as 5, and values above 9 act as 9.
- R6: When `msb_first` = 0, the first data bit received lands at bit 0 of `word_out`. When `msb_first` = 1, the first data bit lands at bit N-1.
- R7: `word_valid` pulses for one clock after the last data bit is sampled. At that point `word_out` holds the word, and all bits at position N and above are 0.
- R8: With `par_en` = 1, the parity slot follows the data. `par_kind` selects the rule: 0 means the data plus the parity bit hold an odd number of ones, 1 means they hold an even number, 2 means the parity bit must be 0, and 3 means it must be 1. A violation pulses `err_parity` when `par_chk` = 1.
- R9: With `par_en` = 0, there is no parity slot, the stop bit is sampled at position N+1, and `err_parity` never asserts. With `par_chk` = 0, the parity slot is still timed, but `err_parity` stays low.
- R10: If the stop bit reads 0, `err_stop` pulses. In both cases the receiver returns to idle, and a new falling edge then starts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial line, idles high |
| clks_per_bit | input | CPB_W | Clocks per bit period, at least 2 |
| data_len | input | 4 | Data bits per frame, clamped to 5..9 |
| par_en | input | 1 | Parity slot present |
| par_kind | input | 2 | 0 odd, 1 even, 2 forced 0, 3 forced 1 |
| par_chk | input | 1 | Enable the parity error flag |
| msb_first | input | 1 | Bit order: 1 = most significant bit first |
| word_out | output | 9 | Assembled data word |
| word_valid | output | 1 | One-clock strobe when the word is complete |
| err_start | output | 1 | One-clock pulse: start bit read high |
| err_parity | output | 1 | One-clock pulse: parity mismatch |
| err_stop | output | 1 | One-clock pulse: stop bit read low |

## Verification
On every clock, the assertions check that reset clears the flags and that each flag lasts a single cycle. They also check that no two flags coincide, because every sample point is distinct, and that no parity error appears when the parity slot is absent.

Sample placement at H + n·P is a different kind of property, as are bit-order assembly, length clamping, parity arithmetic and the continue-after-error behaviour. These depend on the serial stimulus, so only the bench can show them. It does so by comparing against its own clock-by-clock model, across frames at two bit periods, including glitched start bits, broken stop bits and frames sent back to back.

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int CPB_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_line,
  input  logic [CPB_W-1:0] clks_per_bit,
  input  logic [3:0]       data_len,
  input  logic             par_en,
  input  logic [1:0]       par_kind,
  input  logic             par_chk,
  input  logic             msb_first,
  output logic [8:0]       word_out,
  output logic             word_valid,
  output logic             err_start,
  output logic             err_parity,
  output logic             err_stop
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t              st;
  logic             s1, s2, prev;
  logic [CPB_W-1:0] pc, tgt;
  logic [3:0]       nb;
  logic [8:0]       acc;
  logic             par_bad;

  wire [3:0]       nlen  = (data_len < 4'd5) ? 4'd5 : (data_len > 4'd9) ? 4'd9 : data_len;
  wire [CPB_W-1:0] half  = clks_per_bit >> 1;
  wire [CPB_W-1:0] pc_nx = pc + 1'b1;
  wire             hit   = (st != S_IDLE) && (pc_nx == tgt);
  wire             fall  = prev & ~s2;
  wire [3:0]       nb_nx = nb + 4'd1;
  wire [8:0]       ins   = {8'd0, s2} << (nlen - 4'd1);
  wire [8:0]       acc_lsb = (acc >> 1) | ins;
  wire [8:0]       acc_msb = {acc[7:0], s2};
  wire             ones_odd = ^{acc, s2};

  assign word_out = acc;

  always_comb begin
    case (par_kind)
      2'd0:    par_bad = ~ones_odd;
      2'd1:    par_bad = ones_odd;
      2'd2:    par_bad = s2;
      default: par_bad = ~s2;
    endcase
  end

  always_ff @(posedge clk) begin
    s1   <= rx_line;
    s2   <= s1;
    prev <= s2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      pc         <= '0;
      tgt        <= '0;
      nb         <= '0;
      acc        <= '0;
      word_valid <= 1'b0;
      err_start  <= 1'b0;
      err_parity <= 1'b0;
      err_stop   <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      err_start  <= 1'b0;
      err_parity <= 1'b0;
      err_stop   <= 1'b0;
      if (st == S_IDLE) begin
        if (fall) begin
          st  <= S_START;
          pc  <= '0;
          tgt <= half;
        end
      end else begin
        pc <= pc_nx;
        if (hit) begin
          pc  <= '0;
          tgt <= clks_per_bit;
          case (st)
            S_START: begin
              err_start <= s2;
              acc       <= '0;
              nb        <= '0;
              st        <= S_DATA;
            end
            S_DATA: begin
              acc <= msb_first ? acc_msb : acc_lsb;
              nb  <= nb_nx;
              if (nb_nx == nlen) begin
                word_valid <= 1'b1;
                st         <= par_en ? S_PAR : S_STOP;
              end
            end
            S_PAR: begin
              err_parity <= par_chk & par_bad;
              st         <= S_STOP;
            end
            default: begin
              err_stop <= ~s2;
              st       <= S_IDLE;
            end
          endcase
        end
      end
    end
  end

endmodule

module uart_frame_rx_chk (
  input logic clk,
  input logic rst,
  input logic par_en,
  input logic word_valid,
  input logic err_start,
  input logic err_parity,
  input logic err_stop
);

  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> !(word_valid | err_start | err_parity | err_stop));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_start |=> !err_start);

  // R10
  stop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_stop |=> !err_stop);

  // R9
  no_par_chk: assert property (@(posedge clk) disable iff (rst)
    !par_en |-> !err_parity);

  // R3
  flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({word_valid, err_start, err_parity, err_stop}));

endmodule

bind uart_frame_rx uart_frame_rx_chk u_chk (
  .clk(clk), .rst(rst), .par_en(par_en), .word_valid(word_valid),
  .err_start(err_start), .err_parity(err_parity), .err_stop(err_stop)
);

// File: tb/uart_frame_rx_bench.sv
`timescale 1ns/1ps
module uart_frame_rx_bench;
  logic clk = 0, rst = 1, line = 0;
  logic [15:0] cpb = 16'd8;
  logic [3:0] dlen = 4'd8;
  logic pen = 0, pchk = 1, msbf = 0;
  logic [1:0] pkind = 2'd0;
  logic [8:0] word_out;
  logic word_valid, err_start, err_parity, err_stop;

  int total = 0, bad = 0;
  int n_valid = 0, n_es = 0, n_ep = 0, n_ss = 0;
  int cap_word = 0;

  // model state
  int m_s1 = 1, m_s2 = 1, m_prev = 1;
  int m_st = 0, m_el = 0, m_nbit = 0, m_cnt = 0, m_word = 0;
  int e_v = 0, e_es = 0, e_ep = 0, e_ss = 0;

  always #10 clk = ~clk;

  uart_frame_rx u_uart_frame_rx (
    .clk(clk), .rst(rst), .rx_line(line), .clks_per_bit(cpb), .data_len(dlen),
    .par_en(pen), .par_kind(pkind), .par_chk(pchk), .msb_first(msbf),
    .word_out(word_out), .word_valid(word_valid), .err_start(err_start),
    .err_parity(err_parity), .err_stop(err_stop));

  function automatic int eff_len(input int d);
    return d < 5 ? 5 : (d > 9 ? 9 : d);
  endfunction

  function automatic int ones(input int v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += (v >> i) & 1;
    return c;
  endfunction

  always @(posedge clk) begin
    int b, half, n;
    b = m_s2; half = int'(cpb) / 2; n = eff_len(int'(dlen));
    e_v = 0; e_es = 0; e_ep = 0; e_ss = 0;
    if (rst) m_st = 0;
    else if (m_st == 0) begin
      if (m_prev == 1 && m_s2 == 0) begin m_st = 1; m_el = 0; m_nbit = 0; end
    end else begin
      m_el++;
      if (m_el == half + m_nbit * int'(cpb)) begin
        case (m_st)
          1: begin e_es = b; m_word = 0; m_cnt = 0; m_st = 2; end
          2: begin
            if (msbf) m_word = (m_word << 1) | b; else m_word = m_word | (b << m_cnt);
            m_cnt++;
            if (m_cnt == n) begin e_v = 1; m_st = pen ? 3 : 4; end
          end
          3: begin
            int t; t = ones(m_word) + b;
            case (pkind)
              2'd0: e_ep = (t % 2 == 0);
              2'd1: e_ep = (t % 2 == 1);
              2'd2: e_ep = (b != 0);
              default: e_ep = (b != 1);
            endcase
            if (!pchk) e_ep = 0;
            m_st = 4;
          end
          default: begin e_ss = (b == 0); m_st = 0; end
        endcase
        m_nbit++;
      end
    end
    m_prev = m_s2; m_s2 = m_s1; m_s1 = line;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R3 R7 word_valid", word_valid, e_v);
    chk("R4 err_start", err_start, e_es);
    chk("R8 R9 err_parity", err_parity, e_ep);
    chk("R10 err_stop", err_stop, e_ss);
    if (e_v) chk("R6 R7 word_out", word_out, m_word);
    if (word_valid) begin n_valid++; cap_word = word_out; end
    if (err_start) n_es++;
    if (err_parity) n_ep++;
    if (err_stop) n_ss++;
  end

  task automatic put(input int v, input int cyc);
    repeat (cyc) begin @(posedge clk); #2 line = v[0]; end
  endtask

  task automatic frame(input int val, input int n, input bit bstart, input bit bstop, input bit wrongp);
    int cp, p;
    cp = int'(cpb);
    if (bstart) begin put(0, 1); put(1, cp - 1); end else put(0, cp);
    for (int i = 0; i < n; i++) put((val >> (msbf ? n - 1 - i : i)) & 1, cp);
    if (pen) begin
      case (pkind)
        2'd0: p = (ones(val) % 2 == 0);
        2'd1: p = ones(val) % 2;
        2'd2: p = 0;
        default: p = 1;
      endcase
      if (wrongp) p = 1 - p;
      put(p, cp);
    end
    put(bstop ? 0 : 1, cp);
    put(1, 2 * cp);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0;
    repeat (6) @(posedge clk);
    #1 chk("R1 reset valid", word_valid, 0);
    chk("R1 reset flags", err_start | err_parity | err_stop, 0);
    @(posedge clk); #2 rst = 0;
    put(0, 12);
    chk("R1 low line no frame", n_valid + n_es + n_ss, 0);
    put(1, 30);
    chk("R2 rising edge no frame", n_valid + n_es + n_ss, 0);

    frame(9'h0A5, 8, 0, 0, 0);
    chk("R6 lsb-first word", cap_word, 9'h0A5);
    chk("R7 one valid", n_valid, 1);

    msbf = 1; frame(9'h03C, 8, 0, 0, 0);
    chk("R6 msb-first word", cap_word, 9'h03C);
    msbf = 0;

    pen = 1; pkind = 2'd1; dlen = 4'd5; frame(9'h016, 5, 0, 0, 0);
    chk("R8 even ok", n_ep, 0);
    chk("R7 5-bit word", cap_word, 9'h016);
    pkind = 2'd0; dlen = 4'd9; frame(9'h1A7, 9, 0, 0, 1);
    chk("R8 odd wrong", n_ep, 1);
    chk("R6 9-bit word", cap_word, 9'h1A7);

    cpb = 16'd5; dlen = 4'd8; pkind = 2'd2; frame(9'h0C3, 8, 0, 0, 1);
    chk("R8 forced zero wrong", n_ep, 2);
    pkind = 2'd3; pchk = 0; frame(9'h055, 8, 0, 0, 1);
    chk("R9 check off", n_ep, 2);
    pchk = 1; pkind = 2'd3; frame(9'h0AA, 8, 0, 0, 0);
    chk("R8 forced one ok", n_ep, 2);

    pen = 0; dlen = 4'd7; frame(9'h05A, 7, 0, 0, 0);
    frame(9'h023, 7, 0, 0, 0);
    chk("R9 no parity word", cap_word, 9'h023);
    chk("R10 stop ok", n_ss, 0);

    v0 = n_valid;
    dlen = 4'd8; frame(9'h081, 8, 1, 0, 0);
    chk("R4 start flagged", n_es, 1);
    chk("R4 frame continues", n_valid, v0 + 1);

    frame(9'h07E, 8, 0, 1, 0);
    chk("R10 stop flagged", n_ss, 1);
    frame(9'h011, 8, 0, 0, 0);
    chk("R10 next frame", cap_word, 9'h011);

    dlen = 4'd3; frame(9'h015, 5, 0, 0, 0);
    chk("R5 low clamp", cap_word, 9'h015);
    dlen = 4'd12; frame(9'h155, 9, 0, 0, 0);
    chk("R5 high clamp", cap_word, 9'h155);

    put(1, 10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule